// File: doc/BRIEF.md
# Asynchronous SRAM Bridge for an AHB-Lite Host

This block sits on an AHB-Lite bus as a slave. It turns each single read or write into one access on an external asynchronous static RAM. Every access lasts a programmed number of whole clock cycles. The last of these cycles is the one in which the host takes the read data, so the wait-state count sets the read sample point. It must therefore cover the memory's access time. Chip select can also be held back from the start of the access, in steps of half a clock cycle. Output enable, write enable and the byte enables only go active while chip select is active, and all of them are released on the rising edge that ends the access.

The bridge never stores read data. During the final cycle of a read it passes the memory data bus straight to HRDATA, and the host captures it on the rising edge at which HREADY is high. The bidirectional data bus is modelled as three signals: an input, an output, and an output enable. The bus is driven only during the cycles of a write access.

The sequencer has three states:
- IDLE: no access is open. HREADY is high.
- ACCESS: one memory access is in progress, and a counter numbers its cycles.
- GAP: a single turnaround cycle with all strobes off. It is used when a new transfer is accepted in the final cycle of an access.

The sequencer moves between states as follows:
- IDLE stays in IDLE on an IDLE or BUSY transfer.
- IDLE goes to ACCESS when a NONSEQ or SEQ transfer is accepted.
- ACCESS advances its counter until the last cycle.
- From the last cycle, ACCESS goes to IDLE when no transfer is accepted, or to GAP when one is.
- GAP always goes to ACCESS.

Top module: `sram_ahb_bridge`

## Requirements
- R1: While reset is held, HREADY is 1, the signals mem_cs_n, mem_oe_n and mem_we_n are 1, mem_be_n is all ones, and mem_doe is 0.
- R2: An IDLE (htrans 2'b00) or BUSY (2'b01) transfer gets HREADY high with no wait and never asserts chip select, so memory contents are untouched.
- R3: After a NONSEQ (2'b10) or SEQ (2'b11) address phase is accepted, the access lasts N cycles, where N is cfg_wait, or 1 when cfg_wait is 0. HREADY is 0 in the first N-1 of those cycles and 1 in the last.
- R4: During a read, mem_oe_n is low exactly while mem_cs_n is low, and mem_we_n stays high. In the last cycle, hrdata equals mem_din. Outside that cycle, hrdata is zero.
- R5: During a write, mem_doe is 1 in every access cycle, mem_dout equals hwdata, and mem_we_n is low exactly while mem_cs_n is low. mem_oe_n stays high. During a read, mem_doe stays 0.
- R6: Let D be cfg_cs_delay and let the access cycles be numbered from 0. If D is even, chip select asserts at the start of cycle D/2. If D is odd, it asserts at mid-cycle of (D-1)/2. In both cases it releases at the edge that ends the access. If the start point lies beyond the access, chip select does not assert.
- R7: mem_addr carries address bits [15:2] of the accepted address. While chip select is low, mem_be_n bit i is 0 for the lanes the size selects: a byte (hsize 0) selects lane addr[1:0]; a halfword (hsize 1) selects lanes 2*addr[1] and 2*addr[1]+1; a word (hsize 2) selects all four lanes.
- R8: A transfer accepted in the final cycle of an access first gets one turnaround cycle, with HREADY 0, chip select off and mem_doe 0. Its own N-cycle access follows.
- R9: hresp is always 0 (OKAY).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | System clock |
| hresetn | input | 1 | Active-low asynchronous reset |
| haddr | input | AW (16) | Host byte address |
| hwrite | input | 1 | 1 = write transfer |
| htrans | input | 2 | Transfer type |
| hsize | input | 3 | Transfer size |
| hwdata | input | DW (32) | Write data |
| hrdata | output | DW (32) | Read data, valid in the final read cycle |
| hready | output | 1 | Transfer done / slave ready |
| hresp | output | 1 | Response, always OKAY |
| cfg_wait | input | WSW (4) | Access length in cycles (0 is treated as 1) |
| cfg_cs_delay | input | CDW (4) | Chip-select delay in half cycles |
| mem_addr | output | AW-2 (14) | Memory word address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_be_n | output | DW/8 (4) | Byte enables, active low |
| mem_din | input | DW (32) | Data bus from memory |
| mem_dout | output | DW (32) | Data bus to memory |
| mem_doe | output | 1 | Drive enable for the data bus |

## Verification
A counter that runs one cycle too long or too short would show up within a single access: HREADY would rise in the wrong cycle, and on a read hrdata would then carry data from before chip select had settled. A half-cycle register stuck at the wrong value would move the chip-select edge by half a cycle. That is visible at a mid-cycle sample in the very cycle where chip select is due. If the sequencer missed the GAP state, chip select would stay low across two back-to-back accesses, and the first sample after the turnaround edge would show it.

// File: rtl/sram_ahb_pkg.sv
package sram_ahb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_GAP    = 2'd2
    } seq_state_t;

    localparam logic [1:0] TR_IDLE   = 2'b00;
    localparam logic [1:0] TR_BUSY   = 2'b01;
    localparam logic [1:0] TR_NONSEQ = 2'b10;
    localparam logic [1:0] TR_SEQ    = 2'b11;

endpackage

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
    import sram_ahb_pkg::*;
#(
    parameter int WSW = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       htrans_i,
    input  logic [WSW-1:0]   cfg_wait_i,
    output seq_state_t       state_o,
    output seq_state_t       state_nxt_o,
    output logic [WSW-1:0]   cnt_nxt_o,
    output logic             last_o,
    output logic             hready_o,
    output logic             accept_o
);

    localparam logic [WSW-1:0] ONE = WSW'(1);

    seq_state_t     state_q, state_d;
    logic [WSW-1:0] cnt_q, cnt_d;
    logic [WSW-1:0] eff_wait;
    logic           last;
    logic           accept;

    assign eff_wait = (cfg_wait_i == '0) ? ONE : cfg_wait_i;
    assign last     = (state_q == ST_ACCESS) && (cnt_q == eff_wait - ONE);
    assign hready_o = (state_q == ST_IDLE) || last;
    assign accept   = hready_o && ((htrans_i == TR_NONSEQ) || (htrans_i == TR_SEQ));

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = ST_ACCESS;
                    cnt_d   = '0;
                end
            end
            ST_ACCESS: begin
                if (last) begin
                    state_d = accept ? ST_GAP : ST_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + ONE;
                end
            end
            ST_GAP: begin
                state_d = ST_ACCESS;
                cnt_d   = '0;
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign state_o     = state_q;
    assign state_nxt_o = state_d;
    assign cnt_nxt_o   = cnt_d;
    assign last_o      = last;
    assign accept_o    = accept;

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACCESS) |-> (cnt_q < eff_wait)); // R3
    AST_ACCEPT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && accept) |=> (state_q == ST_ACCESS && cnt_q == '0)); // R3
    AST_GAP_THEN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GAP) |=> (state_q == ST_ACCESS)); // R8

endmodule

// File: rtl/sram_strobe_gen.sv
module sram_strobe_gen
    import sram_ahb_pkg::*;
#(
    parameter int WSW       = 4,
    parameter int CDW       = 4,
    parameter bit HALF_STEP = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  seq_state_t      state_i,
    input  seq_state_t      state_nxt_i,
    input  logic [WSW-1:0]  cnt_nxt_i,
    input  logic [CDW-1:0]  cfg_cs_delay_i,
    input  logic            wr_i,
    output logic            cs_o,
    output logic            oe_o,
    output logic            we_o
);

    logic [CDW-2:0] whole_steps;
    logic           cs_rise_q;
    logic           cs_hold;

    assign whole_steps = cfg_cs_delay_i[CDW-1:1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_rise_q <= 1'b0;
        end else begin
            cs_rise_q <= (state_nxt_i == ST_ACCESS) &&
                         (32'(cnt_nxt_i) >= 32'(whole_steps));
        end
    end

    generate
        if (HALF_STEP) begin : g_half
            logic cs_fall_q;
            always_ff @(negedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cs_fall_q <= 1'b0;
                end else begin
                    cs_fall_q <= cs_rise_q;
                end
            end
            assign cs_hold = cfg_cs_delay_i[0] ? (cs_rise_q & cs_fall_q) : cs_rise_q;
        end else begin : g_whole
            logic unused_lsb;
            assign unused_lsb = cfg_cs_delay_i[0];
            assign cs_hold    = cs_rise_q;
        end
    endgenerate

    assign cs_o = cs_hold;
    assign oe_o = cs_hold & ~wr_i;
    assign we_o = cs_hold &  wr_i;

    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(oe_o && we_o)); // R4
    AST_CS_ONLY_IN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i != ST_ACCESS) |-> !cs_o); // R6

endmodule

// File: rtl/sram_ahb_bridge.sv
module sram_ahb_bridge
    import sram_ahb_pkg::*;
#(
    parameter int AW        = 16,
    parameter int DW        = 32,
    parameter int WSW       = 4,
    parameter int CDW       = 4,
    parameter bit HALF_STEP = 1'b1
) (
    input  logic                         hclk,
    input  logic                         hresetn,
    input  logic [AW-1:0]                haddr,
    input  logic                         hwrite,
    input  logic [1:0]                   htrans,
    input  logic [2:0]                   hsize,
    input  logic [DW-1:0]                hwdata,
    output logic [DW-1:0]                hrdata,
    output logic                         hready,
    output logic                         hresp,
    input  logic [WSW-1:0]               cfg_wait,
    input  logic [CDW-1:0]               cfg_cs_delay,
    output logic [AW-$clog2(DW/8)-1:0]   mem_addr,
    output logic                         mem_cs_n,
    output logic                         mem_oe_n,
    output logic                         mem_we_n,
    output logic [DW/8-1:0]              mem_be_n,
    input  logic [DW-1:0]                mem_din,
    output logic [DW-1:0]                mem_dout,
    output logic                         mem_doe
);

    localparam int NB  = DW / 8;
    localparam int BL  = $clog2(NB);
    localparam int MAW = AW - BL;

    function automatic logic [NB-1:0] lane_mask(input logic [BL-1:0] lo, input logic [2:0] sz);
        int nbytes;
        int base;
        logic [NB-1:0] m;
        nbytes = 1 << sz;
        if (nbytes > NB) nbytes = NB;
        base = int'(lo) & ~(nbytes - 1);
        for (int i = 0; i < NB; i++) begin
            m[i] = (i >= base) && (i < base + nbytes);
        end
        return m;
    endfunction

    seq_state_t     state, state_nxt;
    logic [WSW-1:0] cnt_nxt;
    logic           last, accept;
    logic           cs, oe, we;
    logic [MAW-1:0] addr_q;
    logic [NB-1:0]  be_q;
    logic           wr_q;

    sram_seq_ctrl #(.WSW(WSW)) i_seq (
        .clk         (hclk),
        .rst_n       (hresetn),
        .htrans_i    (htrans),
        .cfg_wait_i  (cfg_wait),
        .state_o     (state),
        .state_nxt_o (state_nxt),
        .cnt_nxt_o   (cnt_nxt),
        .last_o      (last),
        .hready_o    (hready),
        .accept_o    (accept)
    );

    always_ff @(posedge hclk or negedge hresetn) begin
        if (!hresetn) begin
            addr_q <= '0;
            be_q   <= '0;
            wr_q   <= 1'b0;
        end else if (accept) begin
            addr_q <= haddr[AW-1:BL];
            be_q   <= lane_mask(haddr[BL-1:0], hsize);
            wr_q   <= hwrite;
        end
    end

    sram_strobe_gen #(.WSW(WSW), .CDW(CDW), .HALF_STEP(HALF_STEP)) i_strobe (
        .clk            (hclk),
        .rst_n          (hresetn),
        .state_i        (state),
        .state_nxt_i    (state_nxt),
        .cnt_nxt_i      (cnt_nxt),
        .cfg_cs_delay_i (cfg_cs_delay),
        .wr_i           (wr_q),
        .cs_o           (cs),
        .oe_o           (oe),
        .we_o           (we)
    );

    assign mem_addr = addr_q;
    assign mem_cs_n = ~cs;
    assign mem_oe_n = ~oe;
    assign mem_we_n = ~we;
    assign mem_be_n = ~(be_q & {NB{cs}});
    assign mem_dout = hwdata;
    assign mem_doe  = (state == ST_ACCESS) && wr_q;
    assign hrdata   = (last && !wr_q) ? mem_din : '0;
    assign hresp    = 1'b0;

    AST_READ_NOT_DRIVEN: assert property (@(posedge hclk) disable iff (!hresetn)
        !mem_oe_n |-> !mem_doe); // R5
    AST_WRITE_DRIVEN: assert property (@(posedge hclk) disable iff (!hresetn)
        !mem_we_n |-> mem_doe); // R5
    AST_BE_WITH_CS: assert property (@(posedge hclk) disable iff (!hresetn)
        mem_cs_n |-> (mem_be_n == '1)); // R7

endmodule

// File: tb/test_sram_ahb_bridge.sv
module test_sram_ahb_bridge;

    typedef struct packed {
        logic        wr;
        logic [15:0] addr;
        logic [2:0]  size;
        logic [31:0] data;
        logic [3:0]  wt;
        logic [3:0]  dly;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 16'h0000, 3'd2, 32'h11223344, 4'd1, 4'd0},
        '{1'b0, 16'h0000, 3'd2, 32'h00000000, 4'd1, 4'd0},
        '{1'b1, 16'h0005, 3'd0, 32'h0000AB00, 4'd3, 4'd1},
        '{1'b1, 16'h0006, 3'd1, 32'hCDEF0000, 4'd2, 4'd2},
        '{1'b0, 16'h0004, 3'd2, 32'h00000000, 4'd4, 4'd3},
        '{1'b1, 16'h0008, 3'd2, 32'hA5A55A5A, 4'd0, 4'd0},
        '{1'b0, 16'h0008, 3'd2, 32'h00000000, 4'd5, 4'd4},
        '{1'b0, 16'h0004, 3'd2, 32'h00000000, 4'd2, 4'd4},
        '{1'b0, 16'h0004, 3'd1, 32'h00000000, 4'd2, 4'd3}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] haddr = '0;
    logic        hwrite = 1'b0;
    logic [1:0]  htrans = 2'b00;
    logic [2:0]  hsize = 3'd2;
    logic [31:0] hwdata = '0;
    logic [31:0] hrdata;
    logic        hready, hresp;
    logic [3:0]  cfg_wait = 4'd1;
    logic [3:0]  cfg_dly = 4'd0;
    logic [13:0] mem_addr;
    logic        mem_cs_n, mem_oe_n, mem_we_n, mem_doe;
    logic [3:0]  mem_be_n;
    logic [31:0] mem_din, mem_dout;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    logic [31:0] mem    [16];
    logic [31:0] shadow [16];

    always #10 clk = ~clk;

    sram_ahb_bridge i_sram_ahb_bridge (
        .hclk(clk), .hresetn(rst_n), .haddr(haddr), .hwrite(hwrite), .htrans(htrans),
        .hsize(hsize), .hwdata(hwdata), .hrdata(hrdata), .hready(hready), .hresp(hresp),
        .cfg_wait(cfg_wait), .cfg_cs_delay(cfg_dly), .mem_addr(mem_addr),
        .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_be_n(mem_be_n),
        .mem_din(mem_din), .mem_dout(mem_dout), .mem_doe(mem_doe)
    );

    assign mem_din = (!mem_cs_n && !mem_oe_n) ? mem[mem_addr[3:0]] : 32'h0;

    always @(posedge clk) begin
        if (!mem_cs_n && !mem_we_n && mem_doe) begin
            for (int b = 0; b < 4; b++) begin
                if (!mem_be_n[b]) mem[mem_addr[3:0]][b*8 +: 8] <= mem_dout[b*8 +: 8];
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] lanes(input logic [1:0] a, input logic [2:0] sz);
        case (sz)
            3'd0:    return 4'b0001 << a;
            3'd1:    return a[1] ? 4'b1100 : 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    task automatic run_vec(input vec_t v);
        int n;
        int whole;
        int half;
        logic [3:0]  m;
        logic [31:0] expd;
        bit cse;
        bit csl;
        n     = (v.wt == 0) ? 1 : int'(v.wt);
        whole = int'(v.dly) >> 1;
        half  = int'(v.dly[0]);
        m     = lanes(v.addr[1:0], v.size);
        @(posedge clk); #2;
        cfg_wait = v.wt; cfg_dly = v.dly;
        haddr = v.addr; hwrite = v.wr; hsize = v.size; htrans = 2'b10;
        #2;
        chk(hready === 1'b1, "R3 ready in address phase", 32'(hready), 32'd1);
        @(posedge clk); #2;
        htrans = 2'b00;
        hwdata = v.data;
        expd = (whole < n) ? shadow[v.addr[5:2]] : 32'h0;
        for (int k = 0; k < n; k++) begin
            if (k == 0) #2;
            else begin @(posedge clk); #4; end
            cse = (k >= whole + half);
            csl = (k >= whole);
            chk(hready === (k == n-1), "R3 hready in access cycle", 32'(hready), 32'(k == n-1));
            chk(mem_cs_n === !cse, "R6 cs early half", 32'(mem_cs_n), 32'(!cse));
            chk(mem_oe_n === !(cse && !v.wr), "R4 oe follows cs", 32'(mem_oe_n), 32'(!(cse && !v.wr)));
            chk(mem_we_n === !(cse && v.wr), "R5 we follows cs", 32'(mem_we_n), 32'(!(cse && v.wr)));
            chk(mem_doe === v.wr, "R5 bus drive", 32'(mem_doe), 32'(v.wr));
            chk(hresp === 1'b0, "R9 okay response", 32'(hresp), 32'd0);
            if (v.wr) chk(mem_dout === v.data, "R5 write data", mem_dout, v.data);
            #10;
            chk(mem_cs_n === !csl, "R6 cs late half", 32'(mem_cs_n), 32'(!csl));
            if (k == n-1) begin
                chk(mem_addr === v.addr[15:2], "R7 word address", 32'(mem_addr), 32'(v.addr[15:2]));
                chk(mem_be_n === (csl ? ~m : 4'hF), "R7 byte enables", 32'(mem_be_n), 32'(csl ? ~m : 4'hF));
                if (!v.wr) chk(hrdata === expd, "R4 read data at sample cycle", hrdata, expd);
            end else if (!v.wr) begin
                chk(hrdata === 32'h0, "R4 hrdata zero before sample cycle", hrdata, 32'h0);
            end
        end
        if (v.wr && whole < n) begin
            for (int b = 0; b < 4; b++) if (m[b]) shadow[v.addr[5:2]][b*8 +: 8] = v.data[b*8 +: 8];
        end
        @(posedge clk); #4;
        chk(mem_cs_n === 1'b1 && mem_doe === 1'b0, "R6 strobes released after access",
            {mem_cs_n, mem_doe}, 32'h2);
        chk(hready === 1'b1, "R3 ready after access", 32'(hready), 32'd1);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            mem[i] = 32'h0;
            shadow[i] = 32'h0;
        end
        #25;
        chk(hready === 1'b1 && mem_cs_n === 1'b1 && mem_oe_n === 1'b1 && mem_we_n === 1'b1,
            "R1 reset strobes", {hready, mem_cs_n, mem_oe_n, mem_we_n}, 32'hF);
        chk(mem_doe === 1'b0 && mem_be_n === 4'hF, "R1 reset bus", {mem_doe, mem_be_n}, 32'hF);
        @(posedge clk); #2;
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R2: IDLE and BUSY transfers
        @(posedge clk); #2;
        cfg_wait = 4'd3; cfg_dly = 4'd0;
        haddr = 16'h0010; hwrite = 1'b1; hwdata = 32'hFFFFFFFF;
        for (int c = 0; c < 4; c++) begin
            htrans = c[0] ? 2'b01 : 2'b00;
            #2;
            chk(hready === 1'b1 && hresp === 1'b0, "R2 zero-wait okay", {hready, hresp}, 32'h2);
            chk(mem_cs_n === 1'b1 && mem_we_n === 1'b1, "R2 memory untouched", {mem_cs_n, mem_we_n}, 32'h3);
            @(posedge clk); #2;
        end
        htrans = 2'b00;
        run_vec('{1'b0, 16'h0010, 3'd2, 32'h0, 4'd1, 4'd0});

        // R8: back-to-back write then read
        @(posedge clk); #2;
        cfg_wait = 4'd2; cfg_dly = 4'd0;
        haddr = 16'h000C; hwrite = 1'b1; hsize = 3'd2; htrans = 2'b10;
        @(posedge clk); #2;
        htrans = 2'b00; hwdata = 32'h0BADF00D;
        #2;
        chk(hready === 1'b0, "R8 first write cycle waits", 32'(hready), 32'd0);
        @(posedge clk); #2;
        chk(hready === 1'b1, "R8 final write cycle ready", 32'(hready), 32'd1);
        haddr = 16'h000C; hwrite = 1'b0; htrans = 2'b11;
        @(posedge clk); #2;
        htrans = 2'b00;
        #2;
        chk(hready === 1'b0 && mem_cs_n === 1'b1 && mem_doe === 1'b0, "R8 turnaround cycle",
            {hready, mem_cs_n, mem_doe}, 32'h2);
        @(posedge clk); #4;
        chk(hready === 1'b0 && mem_cs_n === 1'b0 && mem_oe_n === 1'b0, "R8 second access opens",
            {hready, mem_cs_n, mem_oe_n}, 32'h0);
        @(posedge clk); #14;
        chk(hready === 1'b1, "R8 second access ready", 32'(hready), 32'd1);
        chk(hrdata === 32'h0BADF00D, "R8 read after back-to-back write", hrdata, 32'h0BADF00D);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

endmodule